// File: doc/BRIEF.md
# Receive Message Queue Pointer Controller

This block keeps track of a receive queue that occupies part of a numbered array of message buffers. It holds a write index (the next buffer to fill), a read index (the next buffer for the host to drain) and two bitmaps with one bit per buffer: a "holds a message" flag and an "arrived while still full" flag. The block does not store message payloads. It tells the storage which buffer to write in the cycle a message is accepted.

Arriving messages come in on a valid/ready pair. The ready signal is high whenever the block is not held in its configuration state. There is no other back-pressure: a message offered while ready is high is always consumed, either stored or counted as an overflow. The host drains the queue through a write port. A bit written as 0 clears the selected flag, and a bit written as 1 leaves it alone, so the host can never set a flag. Clearing the flag at the read index moves the read index on. Three one-cycle interrupt pulses report a stored message, a queue that has just filled, and an overflow.

Top module: `rxq_ptr_ctrl`

## Requirements
- R1: After reset the buffer count is 32 and the start index is 0. Both indices equal the start index, both bitmaps are zero, and `empty` is 1.
- R2: An accepted message (`rx_valid` and `rx_ready`) aimed at a buffer whose full flag is clear does the following. `buf_we` is 1 and `buf_idx` equals `wr_ptr` in that cycle. After the edge, that buffer's full flag is set, `wr_ptr` has advanced and `rx_irq` is high for one cycle.
- R3: Host writes use `host_sel`. Bit 1 picks the bitmap (0 = full, 1 = overflow). Bit 0 picks the half (0 = buffers 0-15, 1 = buffers 16-31). Each data bit written 0 clears the matching flag, and each bit written 1 has no effect.
- R4: Clearing the full flag at `rd_ptr` while it is set advances `rd_ptr` by one position.
- R5: Clearing a full flag at any other buffer clears only that flag. Both indices stay unchanged.
- R6: Both indices step from the last buffer back to the start index. The size codes are 0=4, 1=8, 2=12, 3=16, 4=24 and 5 to 7=32 buffers. A start index at or above the buffer count is taken as 0.
- R7: `full_irq` pulses for one cycle after a stored message makes the advanced `wr_ptr` equal to `rd_ptr`, provided `rd_ptr` does not advance in the same cycle.
- R8: A message accepted for a buffer whose full flag is set is handled as follows. `buf_we` stays 0, the buffer's overflow flag is set and `ovf_irq` pulses. `wr_ptr` and the full bitmap do not change.
- R9: When a message and a host clear arrive in the same cycle, the message is judged against the flags as they stood before the clear.
- R10: `incons_err` is 1 exactly when `rd_ptr` differs from `wr_ptr` and the full flag at `rd_ptr` is clear.
- R11: While `cfg_mode` is 1, `rx_ready` is 0. The size code and start index are captured, both indices load the start index, and both bitmaps clear.
- R12: `empty` is 1 exactly when the two indices are equal and the full flag at `rd_ptr` is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 1 | Holds the block in its configuration state |
| cfg_size | input | 3 | Buffer count code |
| cfg_start | input | 5 | First buffer index of the queue |
| rx_valid | input | 1 | A message is offered |
| rx_ready | output | 1 | A message can be taken |
| buf_we | output | 1 | Write the message to buffer `buf_idx` |
| buf_idx | output | 5 | Target buffer of the write |
| host_we | input | 1 | Host flag write strobe |
| host_sel | input | 2 | Bitmap and half select |
| host_wdata | input | 16 | Host data; a 0 bit clears a flag |
| wr_ptr | output | 5 | Next buffer to fill |
| rd_ptr | output | 5 | Next buffer to drain |
| full_lo | output | 16 | Full flags of buffers 0-15 |
| full_hi | output | 16 | Full flags of buffers 16-31 |
| ovf_lo | output | 16 | Overflow flags of buffers 0-15 |
| ovf_hi | output | 16 | Overflow flags of buffers 16-31 |
| empty | output | 1 | The queue holds no message |
| rx_irq | output | 1 | A message was stored |
| full_irq | output | 1 | The queue became full |
| ovf_irq | output | 1 | A message hit a full buffer |
| incons_err | output | 1 | Index and flag disagree |

## Verification
A message arrival and a host clear of the flag at the read index can fall in the same cycle. The bench provokes this by filling every buffer of the queue and then offering one more message together with the clear of the buffer under `rd_ptr`. The expected result is that the message counts as an overflow on that buffer, because it was judged against the flag before the clear, and that `rd_ptr` still advances with the buffer's full flag cleared. A scoreboard model predicts every index, bitmap and pulse of each cycle, and the bench compares them with the outputs.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int unsigned RXQ_NBUF = 32;
  localparam int unsigned RXQ_IW   = $clog2(RXQ_NBUF);
  localparam int unsigned RXQ_HALF = 16;
  localparam int unsigned RXQ_NHALF = RXQ_NBUF / RXQ_HALF;

  typedef logic [RXQ_IW-1:0]   rxq_idx_t;
  typedef logic [RXQ_IW:0]     rxq_cnt_t;
  typedef logic [RXQ_NBUF-1:0] rxq_map_t;

  // size code to buffer count
  function automatic rxq_cnt_t rxq_count(input logic [2:0] code);
    rxq_cnt_t c;
    case (code)
      3'd0: c = rxq_cnt_t'(4);
      3'd1: c = rxq_cnt_t'(8);
      3'd2: c = rxq_cnt_t'(12);
      3'd3: c = rxq_cnt_t'(16);
      3'd4: c = rxq_cnt_t'(24);
      default: c = rxq_cnt_t'(RXQ_NBUF);
    endcase
    return c;
  endfunction
endpackage

// File: rtl/rxq_cfg.sv
module rxq_cfg
  import rxq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_mode,
  input  logic [2:0] cfg_size,
  input  rxq_idx_t   cfg_start,
  output rxq_idx_t   ld_start,
  output rxq_idx_t   start_idx,
  output rxq_idx_t   last_idx
);
  rxq_cnt_t cnt;

  always_comb begin
    cnt = rxq_count(cfg_size);
    ld_start = ({1'b0, cfg_start} < cnt) ? cfg_start : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_idx <= '0;
      last_idx  <= rxq_idx_t'(RXQ_NBUF - 1);
    end else if (cfg_mode) begin
      start_idx <= ld_start;
      last_idx  <= rxq_idx_t'(cnt - 1'b1);
    end
  end
endmodule

// File: rtl/rxq_ptr.sv
module rxq_ptr
  import rxq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  rxq_idx_t load_val,
  input  logic     step,
  input  rxq_idx_t start_idx,
  input  rxq_idx_t last_idx,
  output rxq_idx_t ptr,
  output rxq_idx_t nxt
);
  assign nxt = (ptr == last_idx) ? start_idx : ptr + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n)    ptr <= '0;
    else if (load) ptr <= load_val;
    else if (step) ptr <= nxt;
  end
endmodule

// File: rtl/rxq_bitmap.sv
module rxq_bitmap
  import rxq_pkg::*;
#(
  parameter int unsigned N = RXQ_NBUF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_all,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] bits
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n || clr_all) bits[i] <= 1'b0;
      else if (set_vec[i])   bits[i] <= 1'b1;
      else if (clr_vec[i])   bits[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/rxq_ptr_ctrl.sv
module rxq_ptr_ctrl
  import rxq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_mode,
  input  logic [2:0]  cfg_size,
  input  logic [4:0]  cfg_start,
  input  logic        rx_valid,
  output logic        rx_ready,
  output logic        buf_we,
  output logic [4:0]  buf_idx,
  input  logic        host_we,
  input  logic [1:0]  host_sel,
  input  logic [15:0] host_wdata,
  output logic [4:0]  wr_ptr,
  output logic [4:0]  rd_ptr,
  output logic [15:0] full_lo,
  output logic [15:0] full_hi,
  output logic [15:0] ovf_lo,
  output logic [15:0] ovf_hi,
  output logic        empty,
  output logic        rx_irq,
  output logic        full_irq,
  output logic        ovf_irq,
  output logic        incons_err
);
  rxq_idx_t ld_start, start_idx, last_idx, wr_nxt, rd_nxt;
  rxq_map_t full_map, ovf_map, host_clr, full_clr, ovf_clr, wr_onehot;
  logic     accept, slot_full, rd_adv, fill_hit;

  rxq_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_size(cfg_size),
    .cfg_start(cfg_start), .ld_start(ld_start), .start_idx(start_idx),
    .last_idx(last_idx)
  );

  assign rx_ready  = ~cfg_mode;
  assign accept    = rx_valid & rx_ready;
  assign slot_full = full_map[wr_ptr];
  assign buf_we    = accept & ~slot_full;
  assign buf_idx   = wr_ptr;
  assign wr_onehot = rxq_map_t'(1) << wr_ptr;

  // host clear vector per half; 0 bits clear
  for (genvar h = 0; h < RXQ_NHALF; h++) begin : g_half
    assign host_clr[h*RXQ_HALF +: RXQ_HALF] =
      (host_we && host_sel[0] == 1'(h)) ? ~host_wdata : '0;
  end
  assign full_clr = host_sel[1] ? '0 : host_clr;
  assign ovf_clr  = host_sel[1] ? host_clr : '0;

  assign rd_adv   = ~cfg_mode & full_clr[rd_ptr] & full_map[rd_ptr];
  assign fill_hit = buf_we & (wr_nxt == rd_ptr) & ~rd_adv;

  rxq_ptr u_wr (
    .clk(clk), .rst_n(rst_n), .load(cfg_mode), .load_val(ld_start),
    .step(buf_we), .start_idx(start_idx), .last_idx(last_idx),
    .ptr(wr_ptr), .nxt(wr_nxt)
  );

  rxq_ptr u_rd (
    .clk(clk), .rst_n(rst_n), .load(cfg_mode), .load_val(ld_start),
    .step(rd_adv), .start_idx(start_idx), .last_idx(last_idx),
    .ptr(rd_ptr), .nxt(rd_nxt)
  );

  rxq_bitmap u_full (
    .clk(clk), .rst_n(rst_n), .clr_all(cfg_mode),
    .set_vec(buf_we ? wr_onehot : '0), .clr_vec(full_clr), .bits(full_map)
  );

  rxq_bitmap u_ovf (
    .clk(clk), .rst_n(rst_n), .clr_all(cfg_mode),
    .set_vec((accept && slot_full) ? wr_onehot : '0), .clr_vec(ovf_clr),
    .bits(ovf_map)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_irq   <= 1'b0;
      full_irq <= 1'b0;
      ovf_irq  <= 1'b0;
    end else begin
      rx_irq   <= buf_we;
      full_irq <= fill_hit;
      ovf_irq  <= accept & slot_full;
    end
  end

  assign full_lo    = full_map[RXQ_HALF-1:0];
  assign full_hi    = full_map[RXQ_NBUF-1:RXQ_HALF];
  assign ovf_lo     = ovf_map[RXQ_HALF-1:0];
  assign ovf_hi     = ovf_map[RXQ_NBUF-1:RXQ_HALF];
  assign empty      = (wr_ptr == rd_ptr) & ~full_map[rd_ptr];
  assign incons_err = (wr_ptr != rd_ptr) & ~full_map[rd_ptr];
endmodule

// File: rtl/rxq_chk.sv
module rxq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_mode,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic       buf_we,
  input logic       host_we,
  input logic [4:0] wr_ptr,
  input logic [4:0] rd_ptr,
  input logic       empty,
  input logic       rx_irq,
  input logic       ovf_irq
);
  a_r11_cfg_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mode |-> !rx_ready);

  a_r2_store_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && buf_we) |=> rx_irq);

  a_r8_ovf_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && !buf_we) |=> (ovf_irq && !rx_irq && $stable(wr_ptr)));

  a_r2_wr_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!(rx_valid && rx_ready) && !cfg_mode) |=> $stable(wr_ptr));

  a_r4_rd_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_we && !cfg_mode) |=> $stable(rd_ptr));

  a_r12_empty_eq: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (wr_ptr == rd_ptr));
endmodule

bind rxq_ptr_ctrl rxq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .rx_valid(rx_valid),
  .rx_ready(rx_ready), .buf_we(buf_we), .host_we(host_we),
  .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .empty(empty), .rx_irq(rx_irq),
  .ovf_irq(ovf_irq)
);

// File: tb/sim_rxq_ptr_ctrl.sv
module sim_rxq_ptr_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_mode = 1'b0;
  logic [2:0] cfg_size = '0;
  logic [4:0] cfg_start = '0;
  logic rx_valid = 1'b0;
  logic host_we = 1'b0;
  logic [1:0] host_sel = '0;
  logic [15:0] host_wdata = '0;
  logic rx_ready, buf_we, empty, rx_irq, full_irq, ovf_irq, incons_err;
  logic [4:0] buf_idx, wr_ptr, rd_ptr;
  logic [15:0] full_lo, full_hi, ovf_lo, ovf_hi;

  always #5 clk = ~clk;

  rxq_ptr_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_size(cfg_size),
    .cfg_start(cfg_start), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .buf_we(buf_we), .buf_idx(buf_idx), .host_we(host_we),
    .host_sel(host_sel), .host_wdata(host_wdata), .wr_ptr(wr_ptr),
    .rd_ptr(rd_ptr), .full_lo(full_lo), .full_hi(full_hi),
    .ovf_lo(ovf_lo), .ovf_hi(ovf_hi), .empty(empty), .rx_irq(rx_irq),
    .full_irq(full_irq), .ovf_irq(ovf_irq), .incons_err(incons_err)
  );

  typedef struct packed {
    logic [4:0]  wr, rd;
    logic [31:0] full, ovf;
    logic        emp, rxi, fi, oi;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    n_chk = 0;
  int    n_err = 0;

  // reference state
  logic [4:0]  m_wr = '0, m_rd = '0, m_start = '0, m_last = 5'd31;
  logic [31:0] m_full = '0, m_ovf = '0;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic int unsigned size_of(input logic [2:0] c);
    case (c)
      3'd0: return 4;
      3'd1: return 8;
      3'd2: return 12;
      3'd3: return 16;
      3'd4: return 24;
      default: return 32;
    endcase
  endfunction

  function automatic logic [4:0] step_of(input logic [4:0] p);
    return (p == m_last) ? m_start : p + 5'd1;
  endfunction

  task automatic op(input bit cfg, input logic [2:0] sz, input logic [4:0] st,
                    input bit rx, input bit hwe, input logic [1:0] hsel,
                    input logic [15:0] hdat, input string req);
    exp_t e;
    logic exp_we, sf, radv;
    logic [4:0] idx, nx;
    logic [31:0] clr, clrf, clro, setv;
    int unsigned n;
    @(negedge clk);
    cfg_mode = cfg; cfg_size = sz; cfg_start = st; rx_valid = rx;
    host_we = hwe; host_sel = hsel; host_wdata = hdat;
    e = '0;
    idx = m_wr;
    exp_we = 1'b0;
    if (cfg) begin
      n = size_of(sz);
      m_start = (32'(st) < n) ? st : 5'd0;
      m_last = 5'(n - 1);
      m_wr = m_start; m_rd = m_start; m_full = '0; m_ovf = '0;
    end else begin
      sf = m_full[idx];
      exp_we = rx && !sf;
      clr = '0;
      if (hwe) clr[hsel[0]*16 +: 16] = ~hdat;
      clrf = hsel[1] ? '0 : clr;
      clro = hsel[1] ? clr : '0;
      radv = clrf[m_rd] && m_full[m_rd];
      nx = step_of(m_wr);
      setv = 32'd1 << idx;
      e.fi = exp_we && (nx == m_rd) && !radv;
      e.rxi = exp_we;
      e.oi = rx && sf;
      m_full = (m_full & ~clrf) | (exp_we ? setv : 32'd0);
      m_ovf = (m_ovf & ~clro) | ((rx && sf) ? setv : 32'd0);
      if (exp_we) m_wr = nx;
      if (radv) m_rd = step_of(m_rd);
    end
    e.wr = m_wr; e.rd = m_rd; e.full = m_full; e.ovf = m_ovf;
    e.emp = (m_wr == m_rd) && !m_full[m_rd];
    exp_q.push_back(e);
    tag_q.push_back(req);
    #1;
    check(cfg ? "R11" : req, "rx_ready", 32'(rx_ready), 32'(!cfg));
    check(req, "buf_we", 32'(buf_we), 32'(exp_we));
    if (exp_we) check("R2", "buf_idx", 32'(buf_idx), 32'(idx));
  endtask

  task automatic idle(input string req);
    op(1'b0, 3'd0, 5'd0, 1'b0, 1'b0, 2'd0, 16'hFFFF, req);
  endtask

  task automatic recv(input string req);
    op(1'b0, 3'd0, 5'd0, 1'b1, 1'b0, 2'd0, 16'hFFFF, req);
  endtask

  task automatic hclr(input logic [1:0] sel, input int bitn, input string req);
    op(1'b0, 3'd0, 5'd0, 1'b0, 1'b1, sel, ~(16'd1 << bitn), req);
  endtask

  task automatic conf(input logic [2:0] sz, input logic [4:0] st);
    op(1'b1, sz, st, 1'b1, 1'b0, 2'd0, 16'hFFFF, "R11");
  endtask

  // monitor
  initial begin
    exp_t e;
    string t;
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, "wr_ptr", 32'(wr_ptr), 32'(e.wr));
        check(t, "rd_ptr", 32'(rd_ptr), 32'(e.rd));
        check(t, "full", {full_hi, full_lo}, e.full);
        check(t, "ovf", {ovf_hi, ovf_lo}, e.ovf);
        check("R12", "empty", 32'(empty), 32'(e.emp));
        check(t, "rx_irq", 32'(rx_irq), 32'(e.rxi));
        check("R7", "full_irq", 32'(full_irq), 32'(e.fi));
        check("R8", "ovf_irq", 32'(ovf_irq), 32'(e.oi));
        check("R10", "incons_err", 32'(incons_err), 32'd0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle("R1");                         // reset state
    conf(3'd5, 5'd1);                   // R11: rx offered during cfg is dropped
    idle("R1");
    for (int i = 0; i < 3; i++) recv("R2");
    op(1'b0, 3'd0, 5'd0, 1'b0, 1'b1, 2'd0, 16'hFFFF, "R3"); // writing 1s keeps flags
    hclr(2'd0, 1, "R4");                // drain buffer 1
    for (int i = 0; i < 29; i++) recv("R7"); // wraps 31 -> 1, then fills
    recv("R8");                         // hits full buffer 2
    op(1'b0, 3'd0, 5'd0, 1'b1, 1'b1, 2'd0, ~16'h0004, "R9");
    hclr(2'd2, 2, "R3");                // overflow flag clear
    hclr(2'd0, 10, "R5");               // not at the read index
    conf(3'd0, 5'd2);                   // 4 buffers, queue 2..3
    recv("R6");
    recv("R6");
    conf(3'd0, 5'd7);                   // start beyond count -> 0
    idle("R6");
    conf(3'd4, 5'd20);                  // 24 buffers, queue 20..23
    for (int i = 0; i < 4; i++) recv("R6");
    conf(3'd5, 5'd17);
    recv("R2");
    recv("R2");
    hclr(2'd1, 1, "R3");                // high half, buffer 17
    idle("R4");
    idle("R10");
    @(negedge clk);
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule